// File: doc/BRIEF.md
# Bit-Band Alias Bridge

The bridge sits between a bus master and a memory port. Two 32 MB alias windows each stand for a smaller target region, one 32-bit alias word for each target bit. A read through an alias window fetches the target unit and returns only the addressed bit. A write through an alias window becomes a read followed by a write-back that sets or clears that single bit. The slave port stays closed until the write-back completes, so no other master access can land between the two halves.

Requests outside both windows are forwarded to the memory port as they are, and the memory's read data is returned unchanged. Each master access is accepted with a valid/ready handshake. It is answered by a one-cycle response strobe. Only one request is in flight at any time.

Top module: `bitband_bridge`

## Requirements
- R1: An address whose bits [31:25] match 0x2200_0000 targets base 0x2000_0000, and one matching 0x4200_0000 targets base 0x4000_0000. The target byte address is the base ORed with alias offset bits [24:0] shifted right by 5.
- R2: Size code 0 is a byte, 1 a halfword and 2 a word. The bit index is the alias offset shifted right by 2, masked to 3, 4 or 5 bits for those sizes. Bit n of a unit is bit n%8 of byte (unit address + n/8).
- R3: For an alias access, the target address is cleared to 2-byte alignment for a halfword and to 4-byte alignment for a word. The memory access uses the request's size.
- R4: An alias read issues one memory read of the target unit. It returns the selected bit in s_rdata[0], with every other bit zero.
- R5: An alias write issues a memory read and then a memory write, both at the same address and size. The written unit equals the unit read with only the selected bit changed: set when s_wdata[0] is 1, cleared when it is 0. Write responses carry s_rdata = 0.
- R6: The memory data bus uses little-endian byte lanes. The byte at address A sits in bits [8*A[1:0]+7 : 8*A[1:0]], and a halfword sits in lanes 2*A[1] and 2*A[1]+1. Slave-port data uses the same lanes.
- R7: A request outside both windows goes to the memory port unchanged in address, size, direction and write data. A pass-through read returns the memory data as read.
- R8: s_ready is low from acceptance until the response. No new request is accepted before an alias write's write-back has completed.
- R9: Each accepted request produces exactly one s_rvalid pulse, one cycle long.
- R10: During and after reset, s_ready is high and both m_valid and s_rvalid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Master request valid |
| s_ready | output | 1 | Bridge can accept a request |
| s_addr | input | 32 | Request byte address |
| s_size | input | 2 | 0 byte, 1 halfword, 2 word |
| s_write | input | 1 | 1 write, 0 read |
| s_wdata | input | 32 | Write data, lane placed |
| s_rvalid | output | 1 | One-cycle completion strobe |
| s_rdata | output | 32 | Read data, valid with s_rvalid |
| m_valid | output | 1 | Memory request valid |
| m_ready | input | 1 | Memory accepts request |
| m_addr | output | 32 | Memory byte address |
| m_size | output | 2 | Memory access size |
| m_write | output | 1 | Memory write |
| m_wdata | output | 32 | Memory write data |
| m_resp | input | 1 | Memory completion strobe |
| m_rdata | input | 32 | Memory read data, valid with m_resp |

## Verification
The bench targets misaligned halfword and word alias addresses. A design that skipped the alignment would touch the wrong unit and corrupt a neighbouring byte. Word accesses with bit indexes above 7 check the lane order: a swapped order flips a bit in the wrong byte. A second request is held pending during an alias write to show that nothing slips between the read and the write-back; a bridge that reopened early would let the pending request read stale data. Pass-through writes and reads at offset lanes, plus writes with s_wdata[0] both set and clear, expose forwarding that alters data or a bit value taken from the wrong source.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int BITPOS_W = $clog2(DATA_W);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } seq_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    acc_size_e         size;
    logic              write;
    logic [DATA_W-1:0] wdata;
  } req_t;
endpackage

// File: rtl/bb_window_decode.sv
module bb_window_decode
  import bb_pkg::*;
#(
  parameter int NUM_WIN  = 2,
  parameter int WIN_BITS = 25,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic [ADDR_W-1:0]   addr,
  input  acc_size_e           size,
  output logic                hit,
  output logic [ADDR_W-1:0]   tgt_addr,
  output logic [BITPOS_W-1:0] bus_bit
);
  // One alias word (4 bytes) per target bit (8 per byte).
  localparam int LANE_SHIFT = $clog2(DATA_W / 8);
  localparam int TGT_SHIFT  = LANE_SHIFT + 3;

  logic [WIN_BITS-1:0]             offset;
  logic [NUM_WIN-1:0]              win_hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0]  win_tgt;
  logic [ADDR_W-1:0]               raw_tgt;
  logic [BITPOS_W-1:0]             idx;

  assign offset = addr[WIN_BITS-1:0];
  assign idx    = offset[LANE_SHIFT +: BITPOS_W];

  generate
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      assign win_hit[g] = (addr[ADDR_W-1:WIN_BITS] == ALIAS_BASE[g][ADDR_W-1:WIN_BITS]);
      assign win_tgt[g] = TARGET_BASE[g] | ADDR_W'(offset >> TGT_SHIFT);
    end
  endgenerate

  // Lowest-numbered window wins if parameters ever overlap.
  always_comb begin
    hit     = 1'b0;
    raw_tgt = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        hit     = 1'b1;
        raw_tgt = win_tgt[i];
      end
    end
  end

  always_comb begin
    case (size)
      SZ_HALF: tgt_addr = {raw_tgt[ADDR_W-1:1], 1'b0};
      SZ_WORD: tgt_addr = {raw_tgt[ADDR_W-1:2], 2'b00};
      default: tgt_addr = raw_tgt;
    endcase
  end

  // Position of the selected bit on the lane-placed data bus.
  always_comb begin
    case (size)
      SZ_BYTE: bus_bit = {tgt_addr[1:0], idx[2:0]};
      SZ_HALF: bus_bit = {tgt_addr[1], idx[3:0]};
      default: bus_bit = idx;
    endcase
  end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  localparam int POS_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] rd_word,
  input  logic [POS_W-1:0] bit_pos,
  input  logic             new_val,
  output logic [WIDTH-1:0] merged,
  output logic             sel_bit
);
  logic [WIDTH-1:0] mask;

  assign mask    = {{(WIDTH-1){1'b0}}, 1'b1} << bit_pos;
  assign merged  = new_val ? (rd_word | mask) : (rd_word & ~mask);
  assign sel_bit = rd_word[bit_pos];
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  input  logic in_write,
  input  logic in_alias,
  input  logic held_alias_wr,
  input  logic m_ready,
  input  logic m_resp,
  output logic s_ready,
  output logic s_rvalid,
  output logic accept,
  output logic m_valid,
  output logic op_write,
  output logic cap_read
);
  seq_state_e state_q, state_d;
  logic       op_wr_q, op_wr_d;

  always_comb begin
    state_d  = state_q;
    op_wr_d  = op_wr_q;
    accept   = 1'b0;
    s_ready  = 1'b0;
    s_rvalid = 1'b0;
    m_valid  = 1'b0;
    cap_read = 1'b0;
    case (state_q)
      ST_IDLE: begin
        s_ready = 1'b1;
        if (s_valid) begin
          accept  = 1'b1;
          op_wr_d = in_write & ~in_alias;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        m_valid = 1'b1;
        if (m_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (m_resp) begin
          cap_read = ~op_wr_q;
          if (held_alias_wr && !op_wr_q) begin
            op_wr_d = 1'b1;
            state_d = ST_ISSUE;
          end else begin
            state_d = ST_RESP;
          end
        end
      end
      default: begin
        s_rvalid = 1'b1;
        state_d  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_wr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      op_wr_q <= op_wr_d;
    end
  end

  assign op_write = op_wr_q;

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |=> !s_rvalid); // R9
  AST_BUSY_AT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> !s_ready); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid); // R8
  AST_WB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_write) && held_alias_wr |-> $past(m_resp)); // R5
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int NUM_WIN  = 2,
  parameter int WIN_BITS = 25,
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN-1:0][ADDR_W-1:0] TARGET_BASE = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [1:0]        s_size,
  input  logic              s_write,
  input  logic [DATA_W-1:0] s_wdata,
  output logic              s_rvalid,
  output logic [DATA_W-1:0] s_rdata,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic              m_write,
  output logic [DATA_W-1:0] m_wdata,
  input  logic              m_resp,
  input  logic [DATA_W-1:0] m_rdata
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  // Decode the incoming request.
  acc_size_e           in_size;
  logic                in_hit;
  logic [ADDR_W-1:0]   in_tgt;
  logic [BITPOS_W-1:0] in_bit;

  assign in_size = acc_size_e'(s_size);

  bb_window_decode #(
    .NUM_WIN    (NUM_WIN),
    .WIN_BITS   (WIN_BITS),
    .ALIAS_BASE (ALIAS_BASE),
    .TARGET_BASE(TARGET_BASE)
  ) decode_i (
    .addr    (s_addr),
    .size    (in_size),
    .hit     (in_hit),
    .tgt_addr(in_tgt),
    .bus_bit (in_bit)
  );

  // Sequencer.
  logic accept, op_write, cap_read;
  req_t                req_q;
  logic                hit_q;
  logic [ADDR_W-1:0]   tgt_q;
  logic [BITPOS_W-1:0] bit_q;
  logic [DATA_W-1:0]   rd_q;

  bb_seq seq_i (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .s_valid      (s_valid),
    .in_write     (s_write),
    .in_alias     (in_hit),
    .held_alias_wr(hit_q & req_q.write),
    .m_ready      (m_ready),
    .m_resp       (m_resp),
    .s_ready      (s_ready),
    .s_rvalid     (s_rvalid),
    .accept       (accept),
    .m_valid      (m_valid),
    .op_write     (op_write),
    .cap_read     (cap_read)
  );

  // Request latch, written only on acceptance.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_q <= '0;
      hit_q <= 1'b0;
      tgt_q <= '0;
      bit_q <= '0;
    end else if (accept) begin
      req_q <= '{addr: s_addr, size: in_size, write: s_write, wdata: s_wdata};
      hit_q <= in_hit;
      tgt_q <= in_tgt;
      bit_q <= in_bit;
    end
  end

  // Read-data capture, written only on a read completion.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_q <= '0;
    end else if (cap_read) begin
      rd_q <= m_rdata;
    end
  end

  logic [DATA_W-1:0] merged;
  logic              sel_bit;

  bb_bit_merge #(.WIDTH(DATA_W)) merge_i (
    .rd_word(rd_q),
    .bit_pos(bit_q),
    .new_val(req_q.wdata[0]),
    .merged (merged),
    .sel_bit(sel_bit)
  );

  assign m_addr  = hit_q ? tgt_q : req_q.addr;
  assign m_size  = req_q.size;
  assign m_write = op_write;
  assign m_wdata = hit_q ? merged : req_q.wdata;

  always_comb begin
    if (req_q.write)  s_rdata = '0;
    else if (hit_q)   s_rdata = {{(DATA_W-1){1'b0}}, sel_bit};
    else              s_rdata = rd_q;
  end

  AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_valid && hit_q && m_size == SZ_HALF) |-> !m_addr[0]); // R3
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_valid && hit_q && m_size == SZ_WORD) |-> (m_addr[1:0] == 2'b00)); // R3
  AST_ONE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (m_valid && m_write && hit_q) |-> ($countones(m_wdata ^ rd_q) <= 1)); // R5
  AST_ALIAS_RDATA_NARROW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (s_rvalid && hit_q) |-> (s_rdata[DATA_W-1:1] == '0)); // R4
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    m_valid |-> !s_ready); // R8
endmodule

// File: tb/bitband_bridge_tb_top.sv
module bitband_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_valid, s_ready, s_write, s_rvalid;
  logic [31:0] s_addr, s_wdata, s_rdata;
  logic [1:0]  s_size;
  logic        m_valid, m_ready, m_write, m_resp;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;

  always #5 clk = ~clk;

  bitband_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_size(s_size),
    .s_write(s_write), .s_wdata(s_wdata), .s_rvalid(s_rvalid), .s_rdata(s_rdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_size(m_size),
    .m_write(m_write), .m_wdata(m_wdata), .m_resp(m_resp), .m_rdata(m_rdata)
  );

  // Memory model: 2 KB, index {addr[30], addr[9:0]}, lane-placed bus.
  logic [7:0]  mem [0:2047];
  logic [7:0]  sh  [0:2047];
  int          op_cnt;
  logic        log_wr   [0:15];
  logic [31:0] log_addr [0:15];
  logic [1:0]  log_size [0:15];
  logic [31:0] log_wd   [0:15];
  logic [1:0]  rdy_cnt;

  function automatic int mi(logic [31:0] a);
    return int'({a[30], a[9:0]});
  endfunction

  function automatic bit lane_on(logic [31:0] a, logic [1:0] sz, int k);
    if (sz == 2'd0) return k == int'(a[1:0]);
    if (sz == 2'd1) return (k >> 1) == int'(a[1]);
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) mem[i] <= 8'(i * 29 + 7);
      m_resp  <= 1'b0;
      m_ready <= 1'b0;
      rdy_cnt <= 2'd0;
      op_cnt  <= 0;
      m_rdata <= '0;
    end else begin
      rdy_cnt <= rdy_cnt + 2'd1;
      m_ready <= (rdy_cnt != 2'd2);
      m_resp  <= 1'b0;
      if (m_valid && m_ready) begin
        m_resp <= 1'b1;
        log_wr[op_cnt[3:0]]   <= m_write;
        log_addr[op_cnt[3:0]] <= m_addr;
        log_size[op_cnt[3:0]] <= m_size;
        log_wd[op_cnt[3:0]]   <= m_wdata;
        op_cnt <= op_cnt + 1;
        for (int k = 0; k < 4; k++) begin
          if (m_write && lane_on(m_addr, m_size, k))
            mem[mi({m_addr[31:2], 2'b00}) + k] <= m_wdata[8*k +: 8];
          m_rdata[8*k +: 8] <= mem[mi({m_addr[31:2], 2'b00}) + k];
        end
      end
    end
  end

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Reference model, from the requirements.
  function automatic bit is_alias(logic [31:0] a);
    return (a[31:25] == 7'h11) || (a[31:25] == 7'h21);
  endfunction

  function automatic logic [31:0] ref_tgt(logic [31:0] a, logic [1:0] sz);
    logic [31:0] t;
    t = ((a[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000) | ({7'b0, a[24:0]} >> 5);
    if (sz == 2'd1) t[0] = 1'b0;
    if (sz == 2'd2) t[1:0] = 2'b00;
    return t;
  endfunction

  function automatic int ref_n(logic [31:0] a, logic [1:0] sz);
    if (sz == 2'd0) return int'(a[4:2]);
    if (sz == 2'd1) return int'(a[5:2]);
    return int'(a[6:2]);
  endfunction

  function automatic logic [31:0] ref_access(logic [31:0] a, logic [1:0] sz, logic wr, logic [31:0] wd);
    logic [31:0] r;
    r = '0;
    if (is_alias(a)) begin
      int bi = mi(ref_tgt(a, sz)) + ref_n(a, sz) / 8;
      int bp = ref_n(a, sz) % 8;
      if (wr) sh[bi][bp] = wd[0];
      else    r[0] = sh[bi][bp];
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (wr && lane_on(a, sz, k)) sh[mi({a[31:2], 2'b00}) + k] = wd[8*k +: 8];
        r[8*k +: 8] = sh[mi({a[31:2], 2'b00}) + k];
      end
      if (wr) r = '0;
    end
    return r;
  endfunction

  task automatic do_access(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                           input logic [31:0] wd, output logic [31:0] got);
    int n;
    bit busy_ok;
    @(negedge clk);
    s_addr = a; s_size = sz; s_write = wr; s_wdata = wd; s_valid = 1'b1;
    n = 0;
    while (!s_ready && n < 200) begin @(negedge clk); n++; end
    @(negedge clk);
    s_valid = 1'b0;
    busy_ok = 1'b1;
    n = 0;
    while (!s_rvalid && n < 200) begin
      if (s_ready) busy_ok = 1'b0;
      @(negedge clk); n++;
    end
    got = s_rdata;
    chk(s_rvalid, "R9", "response seen", {31'b0, s_rvalid}, 32'd1);
    chk(busy_ok && !s_ready, "R8", "ready low while busy", {31'b0, busy_ok}, 32'd1);
    @(negedge clk);
    chk(!s_rvalid && s_ready, "R9", "single-cycle response", {30'b0, s_rvalid, s_ready}, 32'd1);
  endtask

  task automatic mem_match(string req);
    int bad = -1;
    for (int i = 0; i < 2048; i++) if (mem[i] !== sh[i] && bad < 0) bad = i;
    chk(bad < 0, req, "memory contents", (bad < 0) ? 32'd0 : {24'b0, mem[bad]},
        (bad < 0) ? 32'd0 : {24'b0, sh[bad]});
  endtask

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  sz;
    logic        wr;
    logic [31:0] wd;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{32'h2200_0000, 2'd0, 1'b0, 32'h0},
    '{32'h2200_0000, 2'd0, 1'b1, 32'h1},
    '{32'h2200_0000, 2'd0, 1'b0, 32'h0},
    '{32'h2200_001C, 2'd0, 1'b1, 32'hFFFF_FFFE},
    '{32'h2200_0420, 2'd1, 1'b1, 32'h1},
    '{32'h2200_0420, 2'd1, 1'b0, 32'h0},
    '{32'h2200_0424, 2'd2, 1'b1, 32'h3},
    '{32'h4200_0844, 2'd2, 1'b0, 32'h0},
    '{32'h4200_0844, 2'd2, 1'b1, 32'hFFFF_FFFE},
    '{32'h4200_0844, 2'd2, 1'b0, 32'h0},
    '{32'h4200_0FFC, 2'd0, 1'b1, 32'h3},
    '{32'h4200_0FFC, 2'd0, 1'b0, 32'h0},
    '{32'h2000_0010, 2'd2, 1'b0, 32'h0},
    '{32'h2000_0012, 2'd1, 1'b1, 32'hBEEF_0000},
    '{32'h2000_0010, 2'd2, 1'b0, 32'h0},
    '{32'h4000_0005, 2'd0, 1'b1, 32'h0000_A500},
    '{32'h4200_00A0, 2'd0, 1'b0, 32'h0},
    '{32'h4200_00BC, 2'd0, 1'b0, 32'h0},
    '{32'h2400_0000, 2'd2, 1'b0, 32'h0}
  };

  initial begin
    logic [31:0] got, exp, tgt;
    int c0, c1;
    for (int i = 0; i < 2048; i++) sh[i] = 8'(i * 29 + 7);
    rst_n = 1'b0; s_valid = 1'b0; s_addr = '0; s_size = '0; s_write = 1'b0; s_wdata = '0;
    repeat (3) @(negedge clk);
    chk(s_ready && !m_valid && !s_rvalid, "R10", "idle during reset",
        {29'b0, s_ready, m_valid, s_rvalid}, 32'd4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(s_ready && !m_valid && !s_rvalid, "R10", "idle after reset",
        {29'b0, s_ready, m_valid, s_rvalid}, 32'd4);

    for (int v = 0; v < NV; v++) begin
      c0  = op_cnt;
      exp = ref_access(VECS[v].a, VECS[v].sz, VECS[v].wr, VECS[v].wd);
      do_access(VECS[v].a, VECS[v].sz, VECS[v].wr, VECS[v].wd, got);
      c1  = op_cnt;
      if (is_alias(VECS[v].a)) begin
        chk(got === exp, VECS[v].wr ? "R5" : "R4", "alias rdata", got, exp);
        mem_match("R1 R2 R6");
        tgt = ref_tgt(VECS[v].a, VECS[v].sz);
        if (VECS[v].wr) begin
          chk(c1 - c0 == 2 && !log_wr[c0[3:0]] && log_wr[c0[3:0] + 4'd1]
              && log_addr[c0[3:0] + 4'd1] == tgt && log_size[c0[3:0] + 4'd1] == VECS[v].sz,
              "R5", "read then write-back", log_addr[c0[3:0] + 4'd1], tgt);
        end
        chk(log_addr[c0[3:0]] == tgt && log_size[c0[3:0]] == VECS[v].sz, "R3",
            "aligned target and size", log_addr[c0[3:0]], tgt);
        if (!VECS[v].wr)
          chk(c1 - c0 == 1 && !log_wr[c0[3:0]], "R4", "one memory read",
              32'(c1 - c0), 32'd1);
      end else begin
        chk(got === exp, "R7", "pass-through rdata", got, exp);
        mem_match("R6 R7");
        chk(c1 - c0 == 1 && log_addr[c0[3:0]] == VECS[v].a && log_size[c0[3:0]] == VECS[v].sz
            && log_wr[c0[3:0]] == VECS[v].wr && (!VECS[v].wr || log_wd[c0[3:0]] == VECS[v].wd),
            "R7", "forwarded unchanged", log_addr[c0[3:0]], VECS[v].a);
      end
    end

    // Atomicity: a second request waits through the whole alias write.
    c0 = op_cnt;
    exp = ref_access(32'h2200_0040, 2'd0, 1'b1, 32'h1);
    @(negedge clk);
    s_addr = 32'h2200_0040; s_size = 2'd0; s_write = 1'b1; s_wdata = 32'h1; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_addr = 32'h2000_0000; s_size = 2'd2; s_write = 1'b0; s_wdata = '0;
    for (int n = 0; n < 200 && !s_ready; n++) @(negedge clk);
    chk(op_cnt - c0 == 2 && log_wr[c0[3:0] + 4'd1], "R8", "write-back done before next accept",
        32'(op_cnt - c0), 32'd2);
    exp = ref_access(32'h2000_0000, 2'd2, 1'b0, 32'h0);
    @(negedge clk);
    s_valid = 1'b0;
    for (int n = 0; n < 200 && !s_rvalid; n++) @(negedge clk);
    chk(s_rdata === exp, "R8", "pending read sees written bit", s_rdata, exp);

    // Word alias, bit 31: lands in the top byte of the word.
    c0  = op_cnt;
    exp = ref_access(32'h4200_007C, 2'd2, 1'b1, 32'h1);
    do_access(32'h4200_007C, 2'd2, 1'b1, 32'h1, got);
    mem_match("R6");
    chk(log_wd[c0[3:0] + 4'd1][31] === 1'b1, "R6", "bit 31 in lane 3",
        log_wd[c0[3:0] + 4'd1], log_wd[c0[3:0] + 4'd1] | 32'h8000_0000);
    exp = ref_access(32'h4200_007C, 2'd2, 1'b0, 32'h0);
    do_access(32'h4200_007C, 2'd2, 1'b0, 32'h0, got);
    chk(got === exp, "R4", "bit 31 read back", got, exp);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule